// File: doc/BRIEF.md
# Program Counter and Instruction Register Unit

This block keeps the address of the current instruction and the last instruction word fetched for a small processor. The processor alternates between a fetch clock and an execute clock after reset, so every instruction takes two clocks. During fetch, the controller asserts the load strobe and selects "hold". The instruction register then takes the memory word at the current address, and the address stays where it is.

During execute, the controller picks one of four address actions with a 2-bit select. It can hold, step to the next word, add a signed relative offset, or load an absolute target that comes from a register read port. The relative offset arrives as two 3-bit instruction fields. The unit joins them and sign-extends the result. All address arithmetic wraps around the address width. Branch-condition evaluation and decode stay in the controller.

Top module: `pc_ir_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `pc` and `ir` both become zero after that edge. Reset has priority over every other input.
- R2: With `pc_act` = 2'b00, `pc` keeps its value across the edge.
- R3: With `pc_act` = 2'b01, `pc` becomes `pc` + 1.
- R4: With `pc_act` = 2'b10, `pc` becomes `pc` plus the sign-extended 6-bit offset {`off_hi`, `off_lo`}. `off_hi` holds the upper three bits, and its bit 2 is the sign bit (range -32 to +31).
- R5: With `pc_act` = 2'b11, `pc` becomes `jmp_addr`.
- R6: With `ir_load` = 1, `ir` takes `mem_word` at the edge. With `ir_load` = 0, `ir` keeps its value whatever `mem_word` carries.
- R7: The `ir_load` capture and the `pc_act` action happen on the same edge and do not affect each other. A fetch (load with hold) leaves `pc` unchanged, and a jump with load does both.
- R8: Increment and relative add wrap modulo 2^ADDR_W. Examples: FFFF + 1 gives 0000, and 0000 - 1 gives FFFF.
- R9: `jmp_addr`, `off_hi` and `off_lo` have no effect on `pc` unless their own action is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pc_act | input | 2 | Address action: 00 hold, 01 step, 10 relative, 11 absolute |
| ir_load | input | 1 | Capture strobe for the instruction register |
| mem_word | input | WORD_W (16) | Memory data at the current address |
| off_hi | input | FLD_W (3) | Upper three offset bits (sign in bit 2) |
| off_lo | input | FLD_W (3) | Lower three offset bits |
| jmp_addr | input | ADDR_W (16) | Absolute target from the register file |
| pc | output | ADDR_W (16) | Current instruction address |
| ir | output | WORD_W (16) | Held instruction word |

## Verification
The relative action is tried with small positive, negative, largest positive (+31) and most negative (-32) offsets. A swapped field order or a zero-extension would give a different address for each of these. Step and relative actions are pushed across the top and bottom of the address space to show the wraparound. Hold and step cycles are run while `jmp_addr` and the offset fields carry unrelated values, which shows those inputs are ignored unless selected. Fetch-style and jump-with-load cycles show that the load strobe and the address action are independent.

// File: rtl/pc_ir_pkg.sv
// Shared definitions for the program counter / instruction register unit.
// Assumes a 2-bit action code driven by the controller every clock.
package pc_ir_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'b00,
        ACT_STEP = 2'b01,
        ACT_REL  = 2'b10,
        ACT_ABS  = 2'b11
    } pc_act_e;
endpackage

// File: rtl/pc_next_calc.sv
// Next-address calculator: purely combinational choice among hold, step,
// signed relative add and absolute load. Assumes ADDR_W > 2*FLD_W.
module pc_next_calc #(
    parameter int ADDR_W = 16,
    parameter int FLD_W  = 3
) (
    input  logic [1:0]        act,
    input  logic [ADDR_W-1:0] cur_pc,
    input  logic [FLD_W-1:0]  fld_hi,
    input  logic [FLD_W-1:0]  fld_lo,
    input  logic [ADDR_W-1:0] abs_tgt,
    output logic [ADDR_W-1:0] nxt_pc
);
    import pc_ir_pkg::*;

    localparam int OFF_W = 2 * FLD_W;
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [OFF_W-1:0]  raw_off;
    logic [ADDR_W-1:0] ext_off;

    // Join the two fields, upper field first, and replicate the sign bit.
    always_comb begin
        raw_off = {fld_hi, fld_lo};
        ext_off = {{EXT_W{raw_off[OFF_W-1]}}, raw_off};
    end

    // Pick the next address; adds wrap at the address width.
    always_comb begin
        unique case (pc_act_e'(act))
            ACT_HOLD: nxt_pc = cur_pc;
            ACT_STEP: nxt_pc = cur_pc + ADDR_W'(1);
            ACT_REL:  nxt_pc = cur_pc + ext_off;
            ACT_ABS:  nxt_pc = abs_tgt;
            default:  nxt_pc = cur_pc;
        endcase
    end
endmodule

// File: rtl/pc_reg.sv
// Address register: clears on synchronous active-low reset, else loads
// the computed next address every clock.
module pc_reg #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    // Hold the current instruction address.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ir_reg.sv
// Instruction register: clears on synchronous active-low reset, captures
// the memory word when the load strobe is high, otherwise keeps its value.
module ir_reg #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] d,
    output logic [WORD_W-1:0] q
);
    // Capture the fetched word on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/pc_ir_unit.sv
// Top: program counter plus instruction register for a two-clock
// fetch/execute machine. The controller drives the action code and the
// load strobe; both take effect on the same rising edge.
module pc_ir_unit #(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 16,
    parameter int FLD_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        pc_act,
    input  logic              ir_load,
    input  logic [WORD_W-1:0] mem_word,
    input  logic [FLD_W-1:0]  off_hi,
    input  logic [FLD_W-1:0]  off_lo,
    input  logic [ADDR_W-1:0] jmp_addr,
    output logic [ADDR_W-1:0] pc,
    output logic [WORD_W-1:0] ir
);
    logic [ADDR_W-1:0] pc_nxt;

    pc_next_calc #(.ADDR_W(ADDR_W), .FLD_W(FLD_W)) u_calc (
        .act     (pc_act),
        .cur_pc  (pc),
        .fld_hi  (off_hi),
        .fld_lo  (off_lo),
        .abs_tgt (jmp_addr),
        .nxt_pc  (pc_nxt)
    );

    pc_reg #(.ADDR_W(ADDR_W)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pc_nxt),
        .q     (pc)
    );

    ir_reg #(.WORD_W(WORD_W)) u_ir (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (ir_load),
        .d     (mem_word),
        .q     (ir)
    );
endmodule

// File: rtl/pc_ir_unit_chk.sv
// Checker for pc_ir_unit: relates port values across one clock edge.
// Attached to every instance of the top through the bind below.
module pc_ir_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int WORD_W = 16,
    parameter int FLD_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        pc_act,
    input logic              ir_load,
    input logic [WORD_W-1:0] mem_word,
    input logic [FLD_W-1:0]  off_hi,
    input logic [FLD_W-1:0]  off_lo,
    input logic [ADDR_W-1:0] jmp_addr,
    input logic [ADDR_W-1:0] pc,
    input logic [WORD_W-1:0] ir
);
    localparam int PAD_W = ADDR_W - 2 * FLD_W;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && ir == '0));

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_act == 2'b00) |=> pc == $past(pc));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_act == 2'b01) |=> pc == ADDR_W'($past(pc) + ADDR_W'(1)));

    assert_rel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_act == 2'b10) |=> pc == ADDR_W'($past(pc)
            + {{PAD_W{$past(off_hi[FLD_W-1])}}, $past(off_hi), $past(off_lo)}));

    assert_abs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_act == 2'b11) |=> pc == $past(jmp_addr));

    assert_ir_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ir_load |=> ir == $past(mem_word));

    assert_ir_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_load |=> $stable(ir));
endmodule

bind pc_ir_unit pc_ir_unit_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .FLD_W(FLD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .pc_act(pc_act), .ir_load(ir_load),
    .mem_word(mem_word), .off_hi(off_hi), .off_lo(off_lo),
    .jmp_addr(jmp_addr), .pc(pc), .ir(ir)
);

// File: tb/pc_ir_unit_tb.sv
`timescale 1ns/1ps
// Bench: vector table walked by one loop, then directed reset checks.
module pc_ir_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pc_act = 2'b00;
    logic        ir_load = 1'b0;
    logic [15:0] mem_word = '0;
    logic [2:0]  off_hi = '0;
    logic [2:0]  off_lo = '0;
    logic [15:0] jmp_addr = '0;
    logic [15:0] pc;
    logic [15:0] ir;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pc_ir_unit u_dut (
        .clk(clk), .rst_n(rst_n), .pc_act(pc_act), .ir_load(ir_load),
        .mem_word(mem_word), .off_hi(off_hi), .off_lo(off_lo),
        .jmp_addr(jmp_addr), .pc(pc), .ir(ir)
    );

    // {act, load, hi, lo, jmp, mem, expected pc, expected ir}
    localparam int NV = 14;
    localparam logic [72:0] VEC [NV] = '{
        {2'b00, 1'b1, 3'b101, 3'b010, 16'h7777, 16'hA001, 16'h0000, 16'hA001}, // R7 fetch
        {2'b01, 1'b0, 3'b011, 3'b011, 16'h8888, 16'hFFFF, 16'h0001, 16'hA001}, // R3 R9
        {2'b10, 1'b0, 3'b000, 3'b101, 16'h9999, 16'h0000, 16'h0006, 16'hA001}, // R4 +5
        {2'b10, 1'b0, 3'b111, 3'b110, 16'h0000, 16'h0000, 16'h0004, 16'hA001}, // R4 -2
        {2'b11, 1'b1, 3'b000, 3'b000, 16'h1234, 16'h5A5A, 16'h1234, 16'h5A5A}, // R5 R7
        {2'b10, 1'b0, 3'b011, 3'b111, 16'h0000, 16'h0000, 16'h1253, 16'h5A5A}, // R4 +31
        {2'b10, 1'b0, 3'b100, 3'b000, 16'h0000, 16'h0000, 16'h1233, 16'h5A5A}, // R4 -32
        {2'b00, 1'b0, 3'b111, 3'b111, 16'hFFFF, 16'h3C3C, 16'h1233, 16'h5A5A}, // R2 R6 R9
        {2'b11, 1'b0, 3'b000, 3'b000, 16'hFFFF, 16'h0000, 16'hFFFF, 16'h5A5A}, // R5
        {2'b01, 1'b0, 3'b000, 3'b000, 16'h0000, 16'h0000, 16'h0000, 16'h5A5A}, // R8 up
        {2'b10, 1'b0, 3'b111, 3'b111, 16'h0000, 16'h0000, 16'hFFFF, 16'h5A5A}, // R8 down
        {2'b10, 1'b0, 3'b000, 3'b001, 16'h0000, 16'h0000, 16'h0000, 16'h5A5A}, // R8 up
        {2'b00, 1'b1, 3'b010, 3'b001, 16'h4321, 16'hC3C3, 16'h0000, 16'hC3C3}, // R6 R7
        {2'b01, 1'b1, 3'b000, 3'b000, 16'h0000, 16'h0F0F, 16'h0001, 16'h0F0F}  // R3 R6
    };
    localparam string TAG [NV] = '{
        "R7", "R3", "R4", "R4", "R5", "R4", "R4",
        "R2", "R5", "R8", "R8", "R8", "R6", "R6"
    };

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    initial begin
        #(5.0 * 20000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state after two edges with rst_n low
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1", "pc after reset", pc, 16'h0000);
        check("R1", "ir after reset", ir, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {pc_act, ir_load, off_hi, off_lo, jmp_addr, mem_word} = VEC[i][72:32];
            @(negedge clk);
            check(TAG[i], "pc", pc, VEC[i][31:16]);
            check(TAG[i], "ir", ir, VEC[i][15:0]);
        end

        // R1: reset wins over a jump with load
        pc_act = 2'b11; ir_load = 1'b1; jmp_addr = 16'hBEEF; mem_word = 16'hCAFE;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "pc reset priority", pc, 16'h0000);
        check("R1", "ir reset priority", ir, 16'h0000);

        // R2 R9: hold while offset fields and target toggle
        rst_n = 1'b1; pc_act = 2'b11; ir_load = 1'b0; jmp_addr = 16'h00A0;
        @(negedge clk);
        pc_act = 2'b00; off_hi = 3'b011; off_lo = 3'b111; jmp_addr = 16'h5555;
        @(negedge clk);
        check("R9", "pc ignores fields on hold", pc, 16'h00A0);
        check("R6", "ir untouched", ir, 16'h0000);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule